// File: doc/BRIEF.md
# Clip-Rectangle Batch Dispatch Sequencer

This block turns one batch-execution request into the dword stream a command ring expects when a batch must be replayed once per clip rectangle. A request carries a rectangle count, two drawing-state words, the batch start address, its used length in bytes and a mode select. For each pass the sequencer reads one rectangle through an index port, validates it, writes a six-dword rectangle packet with inclusive corner coordinates, and then writes a batch packet in one of two formats. When every pass is done it bumps a fence counter and closes the stream with a four-dword store packet that carries the new counter value.

With a rectangle count of zero the batch still runs once, with no rectangle packet in front of it. A misaligned request or a degenerate rectangle ends the request with an error pulse, and the fence counter keeps its value. One dword leaves per cycle while `out_valid` is high. The bench stalls nothing, so the block has no ready input.

The controller has five states. IDLE waits for `start`. CHECK validates the rectangle at the current pass index. RECT emits the rectangle packet. BATCH emits the batch packet. FENCE emits the store packet. The transitions are as follows. IDLE goes to CHECK on an aligned request with a nonzero count. IDLE goes to BATCH on an aligned request with a zero count. IDLE stays in IDLE with an error on a misaligned request. CHECK goes to RECT when the rectangle is valid and to IDLE with an error when it is not. RECT goes to BATCH after six beats. BATCH goes to CHECK when more rectangles remain, and otherwise to FENCE, bumping the counter. FENCE goes to IDLE with `done` after four beats.

Top module: `cliprect_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `out_valid`, `done` and `err` are low, and `seq_count` and `last_enq` are zero.
- R2: A request whose start address or used length has any of bits 2:0 set is rejected. `err` pulses in the cycle after `start`, no dword is emitted, and `seq_count` is unchanged.
- R3: A rectangle is rejected when y2<=y1, x2<=x1, y2<=0 or x2<=0, using signed 16-bit compares. Rejection stops the request at once with an `err` pulse. Dwords from earlier passes stay emitted, nothing more follows, and `seq_count` is unchanged.
- R4: A rectangle packet is six dwords in this order: HDR_RECT, dr1, {y1,x1} (x1 in bits 15:0), {y2-1,x2-1} (x2-1 in bits 15:0), dr4, 0.
- R5: The number of passes is max(count,1). A rectangle packet precedes the batch packet only in passes whose index is below count.
- R6: With `mode_start`=1 the batch packet is two dwords: HDR_BSTART with value 2 in bits 7:6, then the start address with bit 0 set as the non-secure flag.
- R7: With `mode_start`=0 the batch packet is four dwords: HDR_BATCH, start|1, start+used-4, 0.
- R8: After the last pass `last_enq` takes the old counter value and `seq_count` increments by one. The closing packet is HDR_STORE, 20, the new counter value, 0.
- R9: `done` pulses for one cycle, in the cycle after the last store dword. `start` is ignored while `busy` is high.
- R10: During a pass, `rect_idx` presents the index of the pass being processed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, sampled while idle |
| mode_start | input | 1 | 1: two-dword batch packet, 0: four-dword batch packet |
| batch_addr | input | 32 | Batch start address |
| batch_len | input | 32 | Batch used length in bytes |
| dr1 | input | 32 | Drawing-state word placed after the rectangle header |
| dr4 | input | 32 | Drawing-state word placed after the corners |
| rect_count | input | 8 | Number of clip rectangles |
| rect_idx | output | 8 | Index of the rectangle being read |
| rect_x1 | input | 16 | Signed left edge of the indexed rectangle |
| rect_y1 | input | 16 | Signed top edge |
| rect_x2 | input | 16 | Signed exclusive right edge |
| rect_y2 | input | 16 | Signed exclusive bottom edge |
| out_valid | output | 1 | A stream dword is present this cycle |
| out_data | output | 32 | Stream dword |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle rejection pulse |
| seq_count | output | 32 | Fence counter |
| last_enq | output | 32 | Counter value before the latest increment |

## Verification
The assertions assume that the rectangle inputs answer `rect_idx` combinationally and stay stable while that index is held. They also assume that the request fields hold steady for the cycle in which `start` is accepted. The bench models the rectangle list as a table indexed by `rect_idx`, which is rewritten only between requests. It changes the request fields only on falling edges. The single `start` pulse it sends during a running request tests that requests are ignored while busy, and the misaligned address it carries would trip an error if the block accepted it.

// File: rtl/cliprect_pkg.sv
package cliprect_pkg;
    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_CHECK = 3'd1,
        S_RECT  = 3'd2,
        S_BATCH = 3'd3,
        S_FENCE = 3'd4
    } seq_state_t;

    localparam int RECT_BEATS  = 6;
    localparam int FENCE_BEATS = 4;
endpackage

// File: rtl/cliprect_rect_check.sv
module cliprect_rect_check #(
    parameter int DW = 32
) (
    input  logic signed [DW/2-1:0] x1,
    input  logic signed [DW/2-1:0] y1,
    input  logic signed [DW/2-1:0] x2,
    input  logic signed [DW/2-1:0] y2,
    output logic                   ok,
    output logic [DW-1:0]          corner_lo,
    output logic [DW-1:0]          corner_hi
);
    localparam int CW = DW / 2;
    localparam logic signed [CW-1:0] ZERO = '0;
    localparam logic signed [CW-1:0] ONE  = 1;

    logic signed [CW-1:0] x2m, y2m;

    always_comb begin
        ok = (y2 > y1) && (x2 > x1) && (y2 > ZERO) && (x2 > ZERO);
        x2m = x2 - ONE;
        y2m = y2 - ONE;
        corner_lo = {y1, x1};
        corner_hi = {y2m, x2m};
    end
endmodule

// File: rtl/cliprect_fence.sv
module cliprect_fence #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bump,
    output logic [DW-1:0] count,
    output logic [DW-1:0] last
);
    localparam logic [DW-1:0] ONE = 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            last  <= '0;
        end else if (bump) begin
            last  <= count;
            count <= count + ONE;
        end
    end
endmodule

// File: rtl/cliprect_seq.sv
module cliprect_seq
    import cliprect_pkg::*;
#(
    parameter int          DW         = 32,
    parameter int          CNT_W      = 8,
    parameter logic [31:0] HDR_RECT   = 32'h7D80_0003,
    parameter logic [31:0] HDR_BSTART = 32'h1880_0000,
    parameter logic [31:0] HDR_BATCH  = 32'h1800_0002,
    parameter logic [31:0] HDR_STORE  = 32'h1080_0001,
    parameter logic [31:0] FENCE_SLOT = 32'd20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic                 mode_start,
    input  logic [DW-1:0]        batch_addr,
    input  logic [DW-1:0]        batch_len,
    input  logic [DW-1:0]        dr1,
    input  logic [DW-1:0]        dr4,
    input  logic [CNT_W-1:0]     rect_count,
    output logic [CNT_W-1:0]     rect_idx,
    input  logic signed [DW/2-1:0] rect_x1,
    input  logic signed [DW/2-1:0] rect_y1,
    input  logic signed [DW/2-1:0] rect_x2,
    input  logic signed [DW/2-1:0] rect_y2,
    output logic                 out_valid,
    output logic [DW-1:0]        out_data,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic [DW-1:0]        seq_count,
    output logic [DW-1:0]        last_enq
);
    localparam logic [2:0]       RECT_LAST  = 3'(RECT_BEATS - 1);
    localparam logic [2:0]       FENCE_LAST = 3'(FENCE_BEATS - 1);
    localparam logic [CNT_W-1:0] PASS_ONE   = 1;
    localparam logic [2:0]       BEAT_ONE   = 1;
    localparam logic [DW-1:0]    NONSECURE  = 1;
    localparam logic [DW-1:0]    SLOT_BYTES = 4;
    localparam logic [DW-1:0]    START_FMT  = 2 << 6;

    seq_state_t       state_q, state_d;
    logic [2:0]       beat_q, beat_d;
    logic [CNT_W-1:0] pass_q, pass_d, cnt_q;
    logic             mode_q;
    logic [DW-1:0]    addr_q, len_q, dr1_q, dr4_q;
    logic             done_d, err_d, bump;
    logic             rect_ok;
    logic [DW-1:0]    corner_lo, corner_hi;
    logic             misaligned;
    logic [2:0]       batch_last;

    cliprect_rect_check #(.DW(DW)) u_check (
        .x1(rect_x1), .y1(rect_y1), .x2(rect_x2), .y2(rect_y2),
        .ok(rect_ok), .corner_lo(corner_lo), .corner_hi(corner_hi)
    );

    cliprect_fence #(.DW(DW)) u_fence (
        .clk(clk), .rst_n(rst_n), .bump(bump),
        .count(seq_count), .last(last_enq)
    );

    assign misaligned = ((batch_addr | batch_len) & 32'h7) != '0;
    assign batch_last = mode_q ? 3'd1 : 3'd3;
    assign rect_idx   = pass_q;

    // next-state logic
    always_comb begin
        state_d = state_q;
        beat_d  = beat_q;
        pass_d  = pass_q;
        done_d  = 1'b0;
        err_d   = 1'b0;
        bump    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    beat_d = '0;
                    pass_d = '0;
                    if (misaligned)            err_d   = 1'b1;
                    else if (rect_count == '0) state_d = S_BATCH;
                    else                       state_d = S_CHECK;
                end
            end
            S_CHECK: begin
                beat_d = '0;
                if (rect_ok) state_d = S_RECT;
                else begin
                    err_d   = 1'b1;
                    state_d = S_IDLE;
                end
            end
            S_RECT: begin
                if (beat_q == RECT_LAST) begin
                    beat_d  = '0;
                    state_d = S_BATCH;
                end else beat_d = beat_q + BEAT_ONE;
            end
            S_BATCH: begin
                if (beat_q == batch_last) begin
                    beat_d = '0;
                    if ((pass_q + PASS_ONE) < cnt_q) begin
                        pass_d  = pass_q + PASS_ONE;
                        state_d = S_CHECK;
                    end else begin
                        bump    = 1'b1;
                        state_d = S_FENCE;
                    end
                end else beat_d = beat_q + BEAT_ONE;
            end
            S_FENCE: begin
                if (beat_q == FENCE_LAST) begin
                    beat_d  = '0;
                    done_d  = 1'b1;
                    state_d = S_IDLE;
                end else beat_d = beat_q + BEAT_ONE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            beat_q  <= '0;
            pass_q  <= '0;
            cnt_q   <= '0;
            mode_q  <= 1'b0;
            addr_q  <= '0;
            len_q   <= '0;
            dr1_q   <= '0;
            dr4_q   <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            state_q <= state_d;
            beat_q  <= beat_d;
            pass_q  <= pass_d;
            done    <= done_d;
            err     <= err_d;
            if (state_q == S_IDLE && start) begin
                cnt_q  <= rect_count;
                mode_q <= mode_start;
                addr_q <= batch_addr;
                len_q  <= batch_len;
                dr1_q  <= dr1;
                dr4_q  <= dr4;
            end
        end
    end

    // output logic
    always_comb begin
        out_valid = 1'b0;
        out_data  = '0;
        busy      = (state_q != S_IDLE);
        unique case (state_q)
            S_IDLE, S_CHECK: ;
            S_RECT: begin
                out_valid = 1'b1;
                unique case (beat_q)
                    3'd0:    out_data = HDR_RECT;
                    3'd1:    out_data = dr1_q;
                    3'd2:    out_data = corner_lo;
                    3'd3:    out_data = corner_hi;
                    3'd4:    out_data = dr4_q;
                    default: out_data = '0;
                endcase
            end
            S_BATCH: begin
                out_valid = 1'b1;
                unique case (beat_q)
                    3'd0:    out_data = mode_q ? (HDR_BSTART | START_FMT) : HDR_BATCH;
                    3'd1:    out_data = addr_q | NONSECURE;
                    3'd2:    out_data = addr_q + len_q - SLOT_BYTES;
                    default: out_data = '0;
                endcase
            end
            S_FENCE: begin
                out_valid = 1'b1;
                unique case (beat_q)
                    3'd0:    out_data = HDR_STORE;
                    3'd1:    out_data = FENCE_SLOT;
                    3'd2:    out_data = seq_count;
                    default: out_data = '0;
                endcase
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/cliprect_seq_chk.sv
module cliprect_seq_chk #(
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic [DW-1:0] batch_addr,
    input logic [DW-1:0] batch_len,
    input logic          out_valid,
    input logic          busy,
    input logic          done,
    input logic          err,
    input logic [DW-1:0] seq_count,
    input logic [DW-1:0] last_enq
);
    assert_misalign_err_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((batch_addr | batch_len) & 32'h7) != '0) |=> (err && !busy));

    assert_aligned_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && ((batch_addr | batch_len) & 32'h7) == '0) |=> busy);

    assert_single_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done, err}));

    assert_err_keeps_count_R3: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (seq_count == $past(seq_count)));

    assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_count == $past(seq_count)) || (seq_count == $past(seq_count) + 32'd1));

    assert_last_tracks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_count != $past(seq_count)) |-> (last_enq == $past(seq_count)));

    assert_quiet_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || err) |-> !out_valid);
endmodule

bind cliprect_seq cliprect_seq_chk #(.DW(DW)) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start),
    .batch_addr(batch_addr), .batch_len(batch_len),
    .out_valid(out_valid), .busy(busy), .done(done), .err(err),
    .seq_count(seq_count), .last_enq(last_enq)
);

// File: tb/cliprect_seq_test.sv
module cliprect_seq_test;
    localparam logic [31:0] H_RECT   = 32'h7D80_0003;
    localparam logic [31:0] H_BSTART = 32'h1880_0000;
    localparam logic [31:0] H_BATCH  = 32'h1800_0002;
    localparam logic [31:0] H_STORE  = 32'h1080_0001;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mode_start = 1'b0;
    logic [31:0] batch_addr = '0, batch_len = '0, dr1 = '0, dr4 = '0;
    logic [7:0]  rect_count = '0;
    logic [7:0]  rect_idx;
    logic signed [15:0] rect_x1, rect_y1, rect_x2, rect_y2;
    logic out_valid, busy, done, err;
    logic [31:0] out_data, seq_count, last_enq;

    logic signed [15:0] tx1 [8], ty1 [8], tx2 [8], ty2 [8];
    assign rect_x1 = tx1[rect_idx[2:0]];
    assign rect_y1 = ty1[rect_idx[2:0]];
    assign rect_x2 = tx2[rect_idx[2:0]];
    assign rect_y2 = ty2[rect_idx[2:0]];

    always #2.5 clk = ~clk;

    cliprect_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode_start(mode_start),
        .batch_addr(batch_addr), .batch_len(batch_len), .dr1(dr1), .dr4(dr4),
        .rect_count(rect_count), .rect_idx(rect_idx),
        .rect_x1(rect_x1), .rect_y1(rect_y1), .rect_x2(rect_x2), .rect_y2(rect_y2),
        .out_valid(out_valid), .out_data(out_data), .busy(busy), .done(done),
        .err(err), .seq_count(seq_count), .last_enq(last_enq)
    );

    int total = 0;
    int bad = 0;
    logic [31:0] expq [$];
    string       tagq [$];
    logic [31:0] model_cnt = '0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: compare each emitted dword against the scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (expq.size() == 0) chk(1'b0, "R5 extra dword", out_data, 32'h0);
            else begin
                automatic logic [31:0] e = expq.pop_front();
                automatic string t = tagq.pop_front();
                chk(out_data === e, t, out_data, e);
            end
        end
    end

    // watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            chk(1'b0, "watchdog", 32'h0, 32'h1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic push(input logic [31:0] v, input string t);
        expq.push_back(v);
        tagq.push_back(t);
    endtask

    task automatic set_rect(input int i, input int x1, input int y1, input int x2, input int y2);
        tx1[i] = 16'(x1); ty1[i] = 16'(y1); tx2[i] = 16'(x2); ty2[i] = 16'(y2);
    endtask

    task automatic run(input bit m, input logic [31:0] a, input logic [31:0] l,
                       input int n, input bit poke);
        bit exp_err = 0;
        bit got_done = 0, got_err = 0;
        int passes = (n > 0) ? n : 1;
        logic [31:0] old_cnt = model_cnt;
        dr1 = 32'hD1D1_0000 + a;
        dr4 = 32'hD4D4_0000 + l;
        if (((a | l) & 32'h7) != 0) exp_err = 1;
        for (int p = 0; p < passes && !exp_err; p++) begin
            if (p < n) begin
                if (ty2[p] <= ty1[p] || tx2[p] <= tx1[p] || ty2[p] <= 0 || tx2[p] <= 0) begin
                    exp_err = 1;
                    break;
                end
                push(H_RECT, "R4 rect header");
                push(dr1, "R4 dr1");
                push({ty1[p], tx1[p]}, "R4 top-left");
                push({16'(ty2[p] - 16'sd1), 16'(tx2[p] - 16'sd1)}, "R4 bottom-right");
                push(dr4, "R4 dr4");
                push(32'h0, "R4 pad");
            end
            if (m) begin
                push(H_BSTART | 32'h80, "R6 start header");
                push(a | 32'h1, "R6 address");
            end else begin
                push(H_BATCH, "R7 header");
                push(a | 32'h1, "R7 address");
                push(a + l - 32'd4, "R7 end");
                push(32'h0, "R7 pad");
            end
        end
        if (!exp_err) begin
            model_cnt = model_cnt + 1;
            push(H_STORE, "R8 store header");
            push(32'd20, "R8 slot");
            push(model_cnt, "R8 counter");
            push(32'h0, "R8 pad");
        end
        mode_start = m; batch_addr = a; batch_len = l; rect_count = 8'(n);
        start = 1'b1;
        for (int c = 0; c < 2000; c++) begin
            @(negedge clk);
            start = 1'b0;
            if (poke && c == 3) begin
                chk(busy === 1'b1, "R9 busy during run", 32'(busy), 32'h1);
                start = 1'b1; batch_addr = 32'h3;
            end else batch_addr = a;
            if (c == 0 && n > 0 && !(((a | l) & 32'h7) != 0))
                chk(rect_idx === 8'h0, "R10 first index", 32'(rect_idx), 32'h0);
            if (done || err) begin
                got_done = done; got_err = err;
                break;
            end
        end
        start = 1'b0;
        batch_addr = a;
        chk(got_err == exp_err, exp_err ? "R3/R2 err pulse" : "R9 no err", 32'(got_err), 32'(exp_err));
        chk(got_done == !exp_err, "R9 done pulse", 32'(got_done), 32'(!exp_err));
        chk(expq.size() == 0, "R3 stream length", 32'(expq.size()), 32'h0);
        chk(seq_count === model_cnt, "R8 counter value", seq_count, model_cnt);
        if (!exp_err) chk(last_enq === old_cnt, "R8 last enqueued", last_enq, old_cnt);
        @(negedge clk);
        chk(!done && !err, "R9 one-cycle pulse", {30'h0, done, err}, 32'h0);
        expq.delete();
        tagq.delete();
    endtask

    initial begin
        for (int i = 0; i < 8; i++) set_rect(i, 1, 1, 2, 2);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && out_valid === 1'b0, "R1 idle", {30'h0, busy, out_valid}, 32'h0);
        chk(done === 1'b0 && err === 1'b0, "R1 no pulse", {30'h0, done, err}, 32'h0);
        chk(seq_count === 0 && last_enq === 0, "R1 counter", seq_count, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        set_rect(0, 10, 20, 110, 220);
        set_rect(1, 0, 0, 640, 480);
        run(1'b0, 32'h0000_1000, 32'h40, 2, 1'b0);           // R4 R5 R7 R8
        run(1'b1, 32'h0000_2000, 32'h18, 0, 1'b0);           // R5 zero count, R6
        set_rect(2, 5, 7, 6, 8);
        run(1'b1, 32'h0000_3008, 32'h8, 3, 1'b0);            // R6 R10 three passes
        run(1'b0, 32'h0000_1004, 32'h40, 1, 1'b0);           // R2 address
        run(1'b1, 32'h0000_1000, 32'h42, 1, 1'b0);           // R2 length
        set_rect(1, 50, 50, 50, 60);
        run(1'b0, 32'h0000_4000, 32'h10, 3, 1'b0);           // R3 x2<=x1 mid-list
        set_rect(0, 0, -5, 9, 0);
        run(1'b1, 32'h0000_4000, 32'h10, 1, 1'b0);           // R3 y2<=0
        set_rect(0, -3, 2, 0, 9);
        run(1'b1, 32'h0000_4000, 32'h10, 1, 1'b0);           // R3 x2<=0
        set_rect(0, 4, 9, 8, 9);
        run(1'b1, 32'h0000_4000, 32'h10, 1, 1'b0);           // R3 y2<=y1
        set_rect(0, -2, -1, 1, 1);
        run(1'b0, 32'h0000_5000, 32'h20, 1, 1'b0);           // R4 negative corners
        set_rect(0, 1, 1, 2, 2);
        set_rect(1, 3, 3, 9, 9);
        run(1'b0, 32'h0000_6000, 32'h100, 2, 1'b1);          // R9 start ignored while busy

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule